// File: doc/BRIEF.md
# Timer Trigger Source and Gating Control

This block sits next to a general-purpose timer counter and turns one selected trigger line into start and clear requests for that counter. A select code picks one line from four groups: external trigger inputs, a comparator output, a safety clock-monitor line, and the trigger outputs of peer 16-bit timers and peer functional timers. The selected line is edge-detected in the timer clock domain. Each rising edge is one trigger event. The event is then gated by the operating mode, the level of the positive-phase output, the counter's running state and the emergency-stop state.

Two controls shape the gating. The clear-inhibit control blocks clears while the positive-phase output is high. The capture mode ignores it. The start-lock control arms a lockout when the counter stops. While the lockout is armed, trigger events cannot restart the counter until software reads the counter register. A stop caused by an emergency stop does not arm this lockout. Instead, starts stay blocked until a separate release input is pulsed.

Top module: `trig_gate_ctrl`

## Requirements
- R1: Select codes 0 to 7 (binary 00000 to 00111) pick external trigger line `ext_trig[code]`. A rising edge on any other external line has no effect.
- R2: Code 8 (01000) picks `cmp_out` and code 12 (01100) picks `safety_mon`. Every other code from 9 to 15 is treated as no source and never produces a start or clear request.
- R3: In the modes other than capture, codes 16 to 23 pick `tmr_trig[code-16]` and codes 24 to 31 pick `ftm_trig[code-24]`. In capture mode, codes 16 to 31 produce no requests. Mode encoding on `op_mode`: 0 timer, 1 capture, 2 PWM1, 3 PWM2.
- R4: A trigger event is a rising edge of the selected line. The edge is taken against the selected level of the previous cycle. A line held high produces only one event.
- R5: `clr_req` is high for exactly the cycle after a trigger event. The exception is when the mode is not capture, `clr_inhibit` is 1 and `pos_out` is 1 in the event cycle; then there is no clear. Both outputs are 0 during reset.
- R6: In capture mode, `clr_inhibit` has no effect, so every event produces a clear whatever `pos_out` is.
- R7: `start_req` is high in the cycle after a trigger event only if `cnt_running` was 0 in the event cycle and no block from R8 or R9 applies.
- R8: With `start_lock` at 1, the cycle in which `cnt_running` falls arms a lockout, unless `estop` is high in that cycle. The lockout blocks starts from that same cycle on. A `cnt_read` pulse removes the lockout from the following cycle. With `start_lock` at 0, a fall does not arm it.
- R9: While `estop` is high, and afterwards until `estop_release` is pulsed with `estop` low, events produce no start. Clears are still issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_code | input | 5 | Trigger source select code |
| op_mode | input | 2 | Operating mode (0 timer, 1 capture, 2 PWM1, 3 PWM2) |
| clr_inhibit | input | 1 | Block clears while positive output is high |
| start_lock | input | 1 | Arm read-before-restart lockout on stop |
| ext_trig | input | 8 | External trigger lines |
| cmp_out | input | 1 | Comparator output |
| safety_mon | input | 1 | Safety clock-monitor trigger |
| tmr_trig | input | 8 | Peer 16-bit timer triggers |
| ftm_trig | input | 8 | Peer functional-timer triggers |
| cnt_running | input | 1 | Counter is running |
| estop | input | 1 | Emergency stop active |
| estop_release | input | 1 | Release pulse after emergency stop |
| pos_out | input | 1 | Positive-phase output level |
| cnt_read | input | 1 | Strobe marking a read of the counter register |
| start_req | output | 1 | Single-cycle start request |
| clr_req | output | 1 | Single-cycle clear request |

## Verification
The bench sweeps all 32 select codes in both a timer-class mode and capture mode. For each code it pulses only the selected line, then every line except it. A decoder with a wrong reserved slot or a wrong group offset shows up either as a missing event or as a request caused by a neighbouring line. Held-high lines check that a level detector, which would repeat its request every cycle, gets caught. The lockout sequences put a trigger in the very cycle the counter stops and in the cycle of the read strobe. A design that arms the lockout one cycle late, or releases it on the strobe's own cycle, emits an extra start. The emergency-stop sequence releases the stop without pulsing the release input. A design that ties the block to `estop` alone restarts too early.

// File: rtl/trig_gate_pkg.sv
package trig_gate_pkg;
   typedef enum logic [1:0] {
      MODE_TIMER   = 2'd0,
      MODE_CAPTURE = 2'd1,
      MODE_PWM1    = 2'd2,
      MODE_PWM2    = 2'd3
   } op_mode_e;
endpackage

// File: rtl/trig_src_sel.sv
// Source table, capture-mode masking and rising-edge detection.
module trig_src_sel #(
   parameter int unsigned N_LANE = 8,
   localparam int unsigned SEL_W = $clog2(N_LANE) + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  sel_code,
   input  logic              capture_mode,
   input  logic [N_LANE-1:0] ext_trig,
   input  logic              cmp_out,
   input  logic              safety_mon,
   input  logic [N_LANE-1:0] tmr_trig,
   input  logic [N_LANE-1:0] ftm_trig,
   output logic              evt
);
   localparam int unsigned N_CODE   = 1 << SEL_W;
   localparam int unsigned CODE_CMP = N_LANE;
   localparam int unsigned CODE_SAF = N_LANE + N_LANE / 2;

   logic [N_CODE-1:0] src_tab;
   logic [N_CODE-1:0] upper_grp;
   logic              lvl;
   logic              prev_q;

   if (N_LANE < 2 || (N_LANE & (N_LANE - 1)) != 0) begin : g_bad_lane
      $error("trig_src_sel: N_LANE must be a power of two, at least 2");
   end

   for (genvar c = 0; c < N_CODE; c++) begin : g_code
      if (c < N_LANE) begin : g_ext
         assign src_tab[c]   = ext_trig[c];
         assign upper_grp[c] = 1'b0;
      end else if (c == CODE_CMP) begin : g_cmp
         assign src_tab[c]   = cmp_out;
         assign upper_grp[c] = 1'b0;
      end else if (c == CODE_SAF) begin : g_saf
         assign src_tab[c]   = safety_mon;
         assign upper_grp[c] = 1'b0;
      end else if (c < 2 * N_LANE) begin : g_rsv
         assign src_tab[c]   = 1'b0;
         assign upper_grp[c] = 1'b0;
      end else if (c < 3 * N_LANE) begin : g_tmr
         assign src_tab[c]   = tmr_trig[c-2*N_LANE];
         assign upper_grp[c] = 1'b1;
      end else begin : g_ftm
         assign src_tab[c]   = ftm_trig[c-3*N_LANE];
         assign upper_grp[c] = 1'b1;
      end
   end

   assign lvl = src_tab[sel_code] & ~(capture_mode & upper_grp[sel_code]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign evt = lvl & ~prev_q;
endmodule

// File: rtl/trig_lock_ctrl.sv
// Restart lockout after a normal stop and hold after an emergency stop.
module trig_lock_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic cnt_running,
   input  logic estop,
   input  logic estop_release,
   input  logic start_lock,
   input  logic cnt_read,
   output logic start_ok
);
   logic run_q;
   logic pend_q;
   logic hold_q;
   logic arm_now;

   assign arm_now  = run_q & ~cnt_running & start_lock & ~estop;
   assign start_ok = ~(pend_q | arm_now) & ~(estop | hold_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         pend_q <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         run_q <= cnt_running;
         if (arm_now)       pend_q <= 1'b1;
         else if (cnt_read) pend_q <= 1'b0;
         if (estop)              hold_q <= 1'b1;
         else if (estop_release) hold_q <= 1'b0;
      end
   end
endmodule

// File: rtl/trig_gate_ctrl.sv
module trig_gate_ctrl
   import trig_gate_pkg::*;
#(
   parameter int unsigned N_LANE = 8,
   localparam int unsigned SEL_W = $clog2(N_LANE) + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  sel_code,
   input  logic [1:0]        op_mode,
   input  logic              clr_inhibit,
   input  logic              start_lock,
   input  logic [N_LANE-1:0] ext_trig,
   input  logic              cmp_out,
   input  logic              safety_mon,
   input  logic [N_LANE-1:0] tmr_trig,
   input  logic [N_LANE-1:0] ftm_trig,
   input  logic              cnt_running,
   input  logic              estop,
   input  logic              estop_release,
   input  logic              pos_out,
   input  logic              cnt_read,
   output logic              start_req,
   output logic              clr_req
);
   logic capture_mode;
   logic evt;
   logic start_ok;
   logic clr_block;

   assign capture_mode = (op_mode_e'(op_mode) == MODE_CAPTURE);
   assign clr_block    = ~capture_mode & clr_inhibit & pos_out;

   trig_src_sel #(.N_LANE(N_LANE)) u_src (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel_code     (sel_code),
      .capture_mode (capture_mode),
      .ext_trig     (ext_trig),
      .cmp_out      (cmp_out),
      .safety_mon   (safety_mon),
      .tmr_trig     (tmr_trig),
      .ftm_trig     (ftm_trig),
      .evt          (evt)
   );

   trig_lock_ctrl u_lock (
      .clk           (clk),
      .rst_n         (rst_n),
      .cnt_running   (cnt_running),
      .estop         (estop),
      .estop_release (estop_release),
      .start_lock    (start_lock),
      .cnt_read      (cnt_read),
      .start_ok      (start_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_req <= 1'b0;
         clr_req   <= 1'b0;
      end else begin
         clr_req   <= evt & ~clr_block;
         start_req <= evt & start_ok & ~cnt_running;
      end
   end
endmodule

// File: rtl/trig_gate_ctrl_chk.sv
module trig_gate_ctrl_chk #(
   parameter int unsigned N_LANE = 8,
   localparam int unsigned SEL_W = $clog2(N_LANE) + 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SEL_W-1:0] sel_code,
   input logic [1:0]       op_mode,
   input logic             clr_inhibit,
   input logic             start_lock,
   input logic             cnt_running,
   input logic             estop,
   input logic             pos_out,
   input logic             start_req,
   input logic             clr_req
);
   logic rsv_code;
   assign rsv_code = (sel_code > SEL_W'(N_LANE)) && (sel_code < SEL_W'(2 * N_LANE))
                     && (sel_code != SEL_W'(N_LANE + N_LANE / 2));

   // R2: reserved codes stay silent
   p_reserved_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_code |=> !clr_req && !start_req);

   // R3: upper group masked in capture mode
   p_capture_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode == 2'd1) && sel_code[SEL_W-1] |=> !clr_req && !start_req);

   // R5: inhibited clear
   p_clear_inhibit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode != 2'd1) && clr_inhibit && pos_out |=> !clr_req);

   // R7: no start while running
   p_start_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_running |=> !start_req);

   // R8: stop cycle with lockout armed
   p_lock_on_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_lock && $fell(cnt_running) |=> !start_req);

   // R9: emergency stop blocks starts
   p_estop_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      estop |=> !start_req);
endmodule

bind trig_gate_ctrl trig_gate_ctrl_chk #(.N_LANE(N_LANE)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sel_code    (sel_code),
   .op_mode     (op_mode),
   .clr_inhibit (clr_inhibit),
   .start_lock  (start_lock),
   .cnt_running (cnt_running),
   .estop       (estop),
   .pos_out     (pos_out),
   .start_req   (start_req),
   .clr_req     (clr_req)
);

// File: tb/trig_gate_ctrl_test.sv
`timescale 1ns/1ps
module trig_gate_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] sel_code = '0;
   logic [1:0] op_mode = '0;
   logic       clr_inhibit = 1'b0, start_lock = 1'b0;
   logic [7:0] ext_trig = '0, tmr_trig = '0, ftm_trig = '0;
   logic       cmp_out = 1'b0, safety_mon = 1'b0;
   logic       cnt_running = 1'b0, estop = 1'b0, estop_release = 1'b0;
   logic       pos_out = 1'b0, cnt_read = 1'b0;
   logic       start_req, clr_req;

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_tag = "R5";
   bit    done = 1'b0;

   // reference model state
   bit m_prev = 0, m_run = 0, m_pend = 0, m_hold = 0;
   bit e_start = 0, e_clr = 0;

   always #4 clk = ~clk;

   trig_gate_ctrl uut (
      .clk(clk), .rst_n(rst_n), .sel_code(sel_code), .op_mode(op_mode),
      .clr_inhibit(clr_inhibit), .start_lock(start_lock), .ext_trig(ext_trig),
      .cmp_out(cmp_out), .safety_mon(safety_mon), .tmr_trig(tmr_trig),
      .ftm_trig(ftm_trig), .cnt_running(cnt_running), .estop(estop),
      .estop_release(estop_release), .pos_out(pos_out), .cnt_read(cnt_read),
      .start_req(start_req), .clr_req(clr_req)
   );

   function automatic bit pick_level(int code, int md);
      if (code < 8)        return ext_trig[code];
      else if (code == 8)  return cmp_out;
      else if (code == 12) return safety_mon;
      else if (code < 16)  return 1'b0;
      else if (md == 1)    return 1'b0;
      else if (code < 24)  return tmr_trig[code-16];
      else                 return ftm_trig[code-24];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_prev = 0; m_run = 0; m_pend = 0; m_hold = 0; e_start = 0; e_clr = 0;
      end else begin
         bit lvl, ev, arm, lockd, stopd;
         lvl   = pick_level(int'(sel_code), int'(op_mode));
         ev    = lvl && !m_prev;
         arm   = m_run && !cnt_running && start_lock && !estop;
         lockd = m_pend || arm;
         stopd = estop || m_hold;
         e_clr   = ev && !((op_mode != 2'd1) && clr_inhibit && pos_out);
         e_start = ev && !cnt_running && !lockd && !stopd;
         if (arm) m_pend = 1; else if (cnt_read) m_pend = 0;
         if (estop) m_hold = 1; else if (estop_release) m_hold = 0;
         m_prev = lvl;
         m_run  = cnt_running;
      end
   end

   task automatic check_bit(string what, bit act, bit exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0b expected=%0b at %0t", cur_tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            check_bit("start_req in reset (R7)", start_req, 1'b0);
            check_bit("clr_req in reset (R5)", clr_req, 1'b0);
         end else begin
            check_bit("start_req", start_req, e_start);
            check_bit("clr_req", clr_req, e_clr);
         end
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   // bit layout follows the select code numbering of R1 to R3
   task automatic set_lines(logic [31:0] m);
      ext_trig   = m[7:0];
      cmp_out    = m[8];
      safety_mon = m[12];
      tmr_trig   = m[23:16];
      ftm_trig   = m[31:24];
   endtask

   task automatic pulse(logic [31:0] m);
      set_lines(m); cyc(1); set_lines('0); cyc(1);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      cyc(4);
      rst_n = 1'b1;
      cyc(2);
      // R1, R2, R3: sweep every code in timer and capture mode
      for (int md = 0; md < 2; md++) begin
         op_mode = md[1:0];
         for (int c = 0; c < 32; c++) begin
            cur_tag = (c < 8) ? "R1" : (c < 16) ? "R2" : "R3";
            sel_code = c[4:0];
            cyc(1);
            pulse(32'h1 << c);
            pulse(~(32'h1 << c));
            pulse(32'hFFFF_FFFF);
         end
      end
      op_mode = 2'd2; sel_code = 5'd20; cur_tag = "R3"; pulse(32'h0010_0000);
      op_mode = 2'd3; sel_code = 5'd29; pulse(32'h2000_0000);
      // R4: held level, single event
      cur_tag = "R4"; op_mode = 2'd0; sel_code = 5'd3; cyc(1);
      ext_trig = 8'h08; cyc(6); ext_trig = 8'h00; cyc(2); ext_trig = 8'h08; cyc(3);
      sel_code = 5'd4; ext_trig = 8'h18; cyc(2); ext_trig = 8'h00; cyc(2);
      // R5: clear inhibit in timer-class modes
      cur_tag = "R5"; clr_inhibit = 1'b1; pos_out = 1'b1;
      for (int md = 0; md < 4; md += 2) begin op_mode = md[1:0]; pulse(32'h10); end
      op_mode = 2'd3; pulse(32'h10);
      pos_out = 1'b0; pulse(32'h10);
      clr_inhibit = 1'b0; pos_out = 1'b1; pulse(32'h10);
      // R6: capture ignores inhibit
      cur_tag = "R6"; op_mode = 2'd1; clr_inhibit = 1'b1; pulse(32'h10); pos_out = 1'b0; pulse(32'h10);
      clr_inhibit = 1'b0; op_mode = 2'd0;
      // R7: running counter gets clears only
      cur_tag = "R7"; cnt_running = 1'b1; cyc(1); pulse(32'h10); pulse(32'h10);
      cnt_running = 1'b0; cyc(1); pulse(32'h10);
      // R8: lockout until read
      cur_tag = "R8"; start_lock = 1'b1; cnt_running = 1'b1; cyc(2);
      cnt_running = 1'b0; set_lines(32'h10); cyc(1); set_lines('0); cyc(1);
      pulse(32'h10);
      cnt_read = 1'b1; set_lines(32'h10); cyc(1); cnt_read = 1'b0; set_lines('0); cyc(1);
      pulse(32'h10);
      start_lock = 1'b0; cnt_running = 1'b1; cyc(2); cnt_running = 1'b0; pulse(32'h10);
      // R9: emergency stop hold until release
      cur_tag = "R9"; start_lock = 1'b1; cnt_running = 1'b1; cyc(2);
      estop = 1'b1; cnt_running = 1'b0; set_lines(32'h10); cyc(1); set_lines('0); cyc(1);
      pulse(32'h10); estop = 1'b0; cyc(1); pulse(32'h10);
      estop_release = 1'b1; cyc(1); estop_release = 1'b0; pulse(32'h10);
      start_lock = 1'b0;
      // mixed random traffic
      cur_tag = "R7";
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] r;
         r = $urandom;
         sel_code      = ($urandom_range(0, 3) == 0) ? 5'($urandom) : sel_code;
         op_mode       = ($urandom_range(0, 15) == 0) ? 2'($urandom) : op_mode;
         clr_inhibit   = r[0];
         start_lock    = r[1];
         pos_out       = r[2];
         cnt_running   = ($urandom_range(0, 7) == 0) ? ~cnt_running : cnt_running;
         estop         = ($urandom_range(0, 40) == 0);
         estop_release = ($urandom_range(0, 20) == 0);
         cnt_read      = ($urandom_range(0, 10) == 0);
         set_lines($urandom & $urandom);
         cyc(1);
      end
      set_lines('0); cyc(3);
      finish_run();
   end
endmodule